// File: doc/BRIEF.md
# Ethernet Transmit Admission Controller

This block sits between a host bus and the transmit side of a simple Ethernet MAC. It decides when a frame may enter the transmit buffer and when the MAC may begin sending it. The host makes a bid for buffer space in two steps. It first writes a command word and then writes a frame length. The block checks the length. A bad length raises a bid-error flag. A good length makes the block wait until the buffer reports enough free space, and then it raises a ready-now status bit. The host polls that bit. It can instead take a one-cycle interrupt pulse if it has enabled one in the buffer configuration word.

While ready-now is high, each data strobe from the host is counted as one frame byte and passed on as a buffer write enable. The command word holds a two-bit early-start field. When the running byte count reaches the byte count that field selects, or the frame length if that is smaller, the block emits a single start-preamble pulse to the MAC. The command word also carries three per-frame options, which are presented to the MAC for the whole frame: single transmit attempt, no appended CRC and no short-frame padding. It also carries a force bit that discards whatever is buffered. Each frame needs its own command write.

Top module: `txAdmitTop`

## Requirements
- R1: After reset the status word reads zero, ready-now is low, and startTx, flushBuf, rdyIrq, bufWrEn, the three option outputs and frameLen are all zero.
- R2: A length write that does not follow a command write is ignored: neither ready-now (status bit 8) nor bid-error (status bit 7) is set.
- R3: A length write directly after a command write is invalid when it is 0, above MAX_FRAME (1514) or above BUF_BYTES. An invalid length sets bid-error (status bit 7) in the next cycle and drops the bid, so a later length write without a new command is ignored.
- R4: A status read returns the current bid-error value and clears the flag. A second read then returns bit 7 as zero.
- R5: After a valid length, ready-now (status bit 8) rises only once freeSpace is at least the length. It rises one cycle after that condition is first seen.
- R6: Command bits 7:6 select the start threshold: 00 means 5 bytes, 01 means 381, 10 means 1021 and 11 means the full length. startTx is a one-cycle pulse in the cycle after the accepted byte that brings the count to the threshold. It fires exactly once per frame.
- R7: When the selected threshold is larger than the frame length, startTx fires after the last byte of the frame.
- R8: Command bit 9 drives frameSingleAttempt, bit 12 drives frameNoCrc and bit 13 drives frameNoPad. Each takes its value in the cycle after the command write and holds it while the frame loads.
- R9: A command write with bit 8 set produces a one-cycle flushBuf pulse in the next cycle. It abandons the frame in progress, so the byte count restarts from zero for the newly armed bid.
- R10: Once the full length has been written, ready-now clears and bufWrEn stays low for further data strobes. A new command write is needed before another length is accepted.
- R11: When buffer configuration bit 8 is set, rdyIrq pulses for one cycle together with the first cycle of ready-now. When that bit is clear, rdyIrq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWrData | input | 16 | Command word (threshold, force, options) |
| lenWrEn | input | 1 | Frame length write strobe |
| lenWrData | input | 16 | Requested frame length in bytes |
| cfgWrEn | input | 1 | Buffer configuration write strobe |
| cfgWrData | input | 16 | Buffer configuration; bit 8 enables the ready interrupt |
| statRdEn | input | 1 | Status read strobe; clears bid-error |
| statRdData | output | 16 | Status word: bit 8 ready-now, bit 7 bid-error |
| dataWrEn | input | 1 | One frame byte offered by the host |
| bufWrEn | output | 1 | Byte accepted into the transmit buffer |
| freeSpace | input | SPACE_W | Free bytes in the transmit buffer |
| startTx | output | 1 | Start-preamble pulse to the MAC |
| flushBuf | output | 1 | Discard-buffer pulse |
| frameLen | output | SPACE_W | Length of the admitted frame |
| frameSingleAttempt | output | 1 | No retransmission after collision |
| frameNoCrc | output | 1 | MAC must not append CRC |
| frameNoPad | output | 1 | MAC must not pad short frames |
| rdyIrq | output | 1 | Ready interrupt pulse |

## Verification
The bench drives every threshold code, including the cases where the frame is shorter than the threshold. A design that compared against the raw code value instead of the smaller of threshold and length would never start those short frames. A design that did not clear its byte counter on a forced discard would start the next frame early. The bench also holds free space below the requested length to catch a ready flag that ignores space. It checks the length boundaries 0, 1, 1514 and 1515, and it sends stray length writes and extra data strobes. A design that admitted those would raise ready-now without a fresh command or pass surplus bytes into the buffer.

// File: rtl/txAdmitPkg.sv
package txAdmitPkg;

  localparam int REG_W = 16;

  // command word fields
  localparam int CMD_THR_LSB  = 6;
  localparam int CMD_FORCE    = 8;
  localparam int CMD_ONECOLL  = 9;
  localparam int CMD_NOCRC    = 12;
  localparam int CMD_NOPAD    = 13;

  // status and configuration fields
  localparam int STAT_BIDERR  = 7;
  localparam int STAT_READY   = 8;
  localparam int CFG_IRQEN    = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LOAD  = 2'd3
  } bidState_t;

  typedef struct packed {
    logic latchCmd;
    logic latchLen;
    logic clearCount;
    logic countByte;
  } dpStrobe_t;

endpackage

// File: rtl/txAdmitDatapath.sv
module txAdmitDatapath
  import txAdmitPkg::*;
#(
  parameter int MAX_FRAME = 1514,
  parameter int BUF_BYTES = 1536,
  parameter int SPACE_W   = 11,
  parameter int THR_A     = 5,
  parameter int THR_B     = 381,
  parameter int THR_C     = 1021
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [REG_W-1:0]   cmdWrData,
  input  logic [REG_W-1:0]   lenWrData,
  input  logic [SPACE_W-1:0] freeSpace,
  output logic               lenValid,
  output logic               spaceOk,
  output logic               lastByte,
  output logic               startTx,
  output logic               flushBuf,
  output logic [SPACE_W-1:0] frameLen,
  output logic               frameSingleAttempt,
  output logic               frameNoCrc,
  output logic               frameNoPad
);

  localparam int NUM_THR = 3;
  localparam logic [REG_W-1:0] MAX_LEN = REG_W'(MAX_FRAME);
  localparam logic [REG_W-1:0] CAP_LEN = REG_W'(BUF_BYTES);

  logic [1:0]         thrSel;
  logic [SPACE_W-1:0] lenReg;
  logic [SPACE_W-1:0] byteCount;
  logic [SPACE_W-1:0] countNext;
  logic [SPACE_W-1:0] effThr;
  logic [REG_W-1:0]   selVal;
  logic [REG_W-1:0]   thrTable [NUM_THR];
  logic               cmdUnused;

  assign cmdUnused = ^{cmdWrData[REG_W-1:CMD_NOPAD+1], cmdWrData[CMD_NOCRC-1:CMD_ONECOLL+1],
                       cmdWrData[CMD_THR_LSB-1:0]};

  // early-start byte counts, one per threshold code below "full frame"
  for (genvar t = 0; t < NUM_THR; t++) begin : gThr
    localparam int THR_VAL = (t == 0) ? THR_A : ((t == 1) ? THR_B : THR_C);
    assign thrTable[t] = REG_W'(THR_VAL);
  end

  always_comb begin
    unique case (thrSel)
      2'd0:    selVal = thrTable[0];
      2'd1:    selVal = thrTable[1];
      2'd2:    selVal = thrTable[2];
      default: selVal = '0;
    endcase
  end

  always_comb begin
    if (thrSel == 2'b11 || selVal >= REG_W'(lenReg)) effThr = lenReg;
    else                                             effThr = selVal[SPACE_W-1:0];
  end

  assign lenValid  = (lenWrData != '0) && (lenWrData <= MAX_LEN) && (lenWrData <= CAP_LEN);
  assign spaceOk   = (freeSpace >= lenReg);
  assign countNext = byteCount + SPACE_W'(1);
  assign lastByte  = (countNext == lenReg);
  assign frameLen  = lenReg;

  // latched command options
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrSel             <= '0;
      frameSingleAttempt <= 1'b0;
      frameNoCrc         <= 1'b0;
      frameNoPad         <= 1'b0;
    end else if (strobe.latchCmd) begin
      thrSel             <= cmdWrData[CMD_THR_LSB+1:CMD_THR_LSB];
      frameSingleAttempt <= cmdWrData[CMD_ONECOLL];
      frameNoCrc         <= cmdWrData[CMD_NOCRC];
      frameNoPad         <= cmdWrData[CMD_NOPAD];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                lenReg <= '0;
    else if (strobe.latchLen) lenReg <= lenWrData[SPACE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  byteCount <= '0;
    else if (strobe.clearCount) byteCount <= '0;
    else if (strobe.countByte)  byteCount <= countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startTx  <= 1'b0;
      flushBuf <= 1'b0;
    end else begin
      startTx  <= strobe.countByte && (countNext == effThr);
      flushBuf <= strobe.latchCmd && cmdWrData[CMD_FORCE];
    end
  end

endmodule

// File: rtl/txAdmitCtrl.sv
module txAdmitCtrl
  import txAdmitPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrEn,
  input  logic      lenWrEn,
  input  logic      statRdEn,
  input  logic      cfgWrEn,
  input  logic      cfgIrqBit,
  input  logic      dataWrEn,
  input  logic      lenValid,
  input  logic      spaceOk,
  input  logic      lastByte,
  output dpStrobe_t strobe,
  output logic      readyNow,
  output logic      bidErr,
  output logic      rdyIrq,
  output logic      bufWrEn
);

  bidState_t state;
  bidState_t stateNext;
  logic      bidErrSet;
  logic      irqEn;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    bidErrSet = 1'b0;
    if (cmdWrEn) begin
      // every command write re-arms and restarts the byte count
      stateNext         = ST_ARMED;
      strobe.latchCmd   = 1'b1;
      strobe.clearCount = 1'b1;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (lenWrEn) begin
            if (lenValid) begin
              stateNext       = ST_WAIT;
              strobe.latchLen = 1'b1;
            end else begin
              stateNext = ST_IDLE;
              bidErrSet = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (spaceOk) stateNext = ST_LOAD;
        end
        ST_LOAD: begin
          if (dataWrEn) begin
            strobe.countByte = 1'b1;
            if (lastByte) stateNext = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          bidErr <= 1'b0;
    else if (bidErrSet) bidErr <= 1'b1;
    else if (statRdEn)  bidErr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        irqEn <= 1'b0;
    else if (cfgWrEn) irqEn <= cfgIrqBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdyIrq <= 1'b0;
    else       rdyIrq <= irqEn && (stateNext == ST_LOAD) && (state != ST_LOAD);
  end

  assign readyNow = (state == ST_LOAD);
  assign bufWrEn  = readyNow && dataWrEn && !cmdWrEn;

endmodule

// File: rtl/txAdmitTop.sv
module txAdmitTop
  import txAdmitPkg::*;
#(
  parameter int MAX_FRAME = 1514,
  parameter int BUF_BYTES = 1536,
  parameter int SPACE_W   = $clog2(BUF_BYTES + 1),
  parameter int THR_A     = 5,
  parameter int THR_B     = 381,
  parameter int THR_C     = 1021
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [15:0]        cmdWrData,
  input  logic               lenWrEn,
  input  logic [15:0]        lenWrData,
  input  logic               cfgWrEn,
  input  logic [15:0]        cfgWrData,
  input  logic               statRdEn,
  output logic [15:0]        statRdData,
  input  logic               dataWrEn,
  output logic               bufWrEn,
  input  logic [SPACE_W-1:0] freeSpace,
  output logic               startTx,
  output logic               flushBuf,
  output logic [SPACE_W-1:0] frameLen,
  output logic               frameSingleAttempt,
  output logic               frameNoCrc,
  output logic               frameNoPad,
  output logic               rdyIrq
);

  dpStrobe_t strobe;
  logic      lenValid;
  logic      spaceOk;
  logic      lastByte;
  logic      readyNow;
  logic      bidErr;
  logic      cfgUnused;

  assign cfgUnused = ^{cfgWrData[15:CFG_IRQEN+1], cfgWrData[CFG_IRQEN-1:0]};

  txAdmitCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .lenWrEn   (lenWrEn),
    .statRdEn  (statRdEn),
    .cfgWrEn   (cfgWrEn),
    .cfgIrqBit (cfgWrData[CFG_IRQEN]),
    .dataWrEn  (dataWrEn),
    .lenValid  (lenValid),
    .spaceOk   (spaceOk),
    .lastByte  (lastByte),
    .strobe    (strobe),
    .readyNow  (readyNow),
    .bidErr    (bidErr),
    .rdyIrq    (rdyIrq),
    .bufWrEn   (bufWrEn)
  );

  txAdmitDatapath #(
    .MAX_FRAME (MAX_FRAME),
    .BUF_BYTES (BUF_BYTES),
    .SPACE_W   (SPACE_W),
    .THR_A     (THR_A),
    .THR_B     (THR_B),
    .THR_C     (THR_C)
  ) uData (
    .clk                (clk),
    .rstN               (rstN),
    .strobe             (strobe),
    .cmdWrData          (cmdWrData),
    .lenWrData          (lenWrData),
    .freeSpace          (freeSpace),
    .lenValid           (lenValid),
    .spaceOk            (spaceOk),
    .lastByte           (lastByte),
    .startTx            (startTx),
    .flushBuf           (flushBuf),
    .frameLen           (frameLen),
    .frameSingleAttempt (frameSingleAttempt),
    .frameNoCrc         (frameNoCrc),
    .frameNoPad         (frameNoPad)
  );

  always_comb begin
    statRdData              = '0;
    statRdData[STAT_READY]  = readyNow;
    statRdData[STAT_BIDERR] = bidErr;
  end

endmodule

// File: rtl/txAdmitChecker.sv
module txAdmitChecker #(
  parameter int SPACE_W = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdWrEn,
  input logic               cmdForce,
  input logic               lenWrEn,
  input logic               readyNow,
  input logic               bidErr,
  input logic [SPACE_W-1:0] freeSpace,
  input logic [SPACE_W-1:0] frameLen,
  input logic               bufWrEn,
  input logic               startTx,
  input logic               flushBuf,
  input logic               rdyIrq,
  input logic               frameSingleAttempt,
  input logic               frameNoCrc,
  input logic               frameNoPad
);

  AST_BIDERR_FROM_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bidErr) |-> ($past(lenWrEn) && !$past(cmdWrEn))); // R3

  AST_READY_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyNow) |-> ($past(freeSpace) >= $past(frameLen))); // R5

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startTx |=> !startTx); // R6

  AST_START_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    startTx |-> $past(bufWrEn)); // R6

  AST_OPTS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (readyNow && $past(readyNow)) |->
      ($stable(frameSingleAttempt) && $stable(frameNoCrc) && $stable(frameNoPad))); // R8

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    flushBuf |-> ($past(cmdWrEn) && $past(cmdForce))); // R9

  AST_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> readyNow); // R10

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    rdyIrq |-> (readyNow && !$past(readyNow))); // R11

endmodule

bind txAdmitTop txAdmitChecker #(.SPACE_W(SPACE_W)) uChecker (
  .clk                (clk),
  .rstN               (rstN),
  .cmdWrEn            (cmdWrEn),
  .cmdForce           (cmdWrData[8]),
  .lenWrEn            (lenWrEn),
  .readyNow           (statRdData[8]),
  .bidErr             (statRdData[7]),
  .freeSpace          (freeSpace),
  .frameLen           (frameLen),
  .bufWrEn            (bufWrEn),
  .startTx            (startTx),
  .flushBuf           (flushBuf),
  .rdyIrq             (rdyIrq),
  .frameSingleAttempt (frameSingleAttempt),
  .frameNoCrc         (frameNoCrc),
  .frameNoPad         (frameNoPad)
);

// File: tb/txAdmitTop_test.sv
module txAdmitTop_test;

  localparam int PERIOD  = 10;
  localparam int SPACE_W = 11;

  logic               clk = 1'b0;
  logic               rstN;
  logic               cmdWrEn, lenWrEn, cfgWrEn, statRdEn, dataWrEn;
  logic [15:0]        cmdWrData, lenWrData, cfgWrData;
  logic [15:0]        statRdData;
  logic               bufWrEn, startTx, flushBuf, rdyIrq;
  logic               frameSingleAttempt, frameNoCrc, frameNoPad;
  logic [SPACE_W-1:0] freeSpace, frameLen;

  int  checks = 0;
  int  errors = 0;
  int  sentBytes = 0;
  int  expQ[$];
  bit  done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  txAdmitTop uut (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .statRdEn(statRdEn), .statRdData(statRdData),
    .dataWrEn(dataWrEn), .bufWrEn(bufWrEn),
    .freeSpace(freeSpace), .startTx(startTx), .flushBuf(flushBuf),
    .frameLen(frameLen), .frameSingleAttempt(frameSingleAttempt),
    .frameNoCrc(frameNoCrc), .frameNoPad(frameNoPad), .rdyIrq(rdyIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCmd(input logic [15:0] v);
    cmdWrData = v; cmdWrEn = 1'b1; sentBytes = 0;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic writeLen(input logic [15:0] v);
    lenWrData = v; lenWrEn = 1'b1;
    @(negedge clk);
    lenWrEn = 1'b0;
  endtask

  task automatic writeCfg(input logic [15:0] v);
    cfgWrData = v; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic readStat(output logic [15:0] v);
    statRdEn = 1'b1;
    #1 v = statRdData;
    @(negedge clk);
    statRdEn = 1'b0;
  endtask

  task automatic sendBytes(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      dataWrEn = 1'b1;
      sentBytes++;
      #1 if (bufWrEn) acc++;
      @(negedge clk);
    end
    dataWrEn = 1'b0;
  endtask

  // scoreboard driver: arm, bid, wait for ready, load, expect start at expThr
  task automatic runFrame(input logic [15:0] cmd, input int len, input int expThr, input string tag);
    int acc;
    writeCmd(cmd);
    expQ.push_back(expThr);
    writeLen(16'(len));
    @(negedge clk);
    check(statRdData[8] == 1'b1, {tag, " ready-now after bid"}, int'(statRdData[8]), 1);
    sendBytes(len, acc);
    check(acc == len, {tag, " bytes accepted"}, acc, len);
    check(statRdData[8] == 1'b0, "R10 ready-now cleared after full frame", int'(statRdData[8]), 0);
  endtask

  // scoreboard monitor: each start pulse must match the oldest expected byte position
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (rstN === 1'b1 && startTx === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected startTx at byte", sentBytes, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(sentBytes == e, "R6 R7 startTx byte position", sentBytes, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] st;
    int acc;
    rstN = 1'b0; cmdWrEn = 0; lenWrEn = 0; cfgWrEn = 0; statRdEn = 0; dataWrEn = 0;
    cmdWrData = '0; lenWrData = '0; cfgWrData = '0; freeSpace = 11'd1536;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(statRdData == 16'h0, "R1 status after reset", int'(statRdData), 0);
    check({startTx, flushBuf, rdyIrq, bufWrEn} == 4'b0, "R1 pulses after reset",
          int'({startTx, flushBuf, rdyIrq, bufWrEn}), 0);
    check({frameSingleAttempt, frameNoCrc, frameNoPad} == 3'b0 && frameLen == '0,
          "R1 options and length after reset", int'(frameLen), 0);

    // R2 length without command
    writeLen(16'd60);
    repeat (2) @(negedge clk);
    readStat(st);
    check(st == 16'h0, "R2 stray length ignored", int'(st), 0);

    // R6 each threshold code
    runFrame(16'h0000, 100, 5, "R6 code00");
    sendBytes(3, acc);
    check(acc == 0, "R10 extra bytes rejected", acc, 0);
    writeLen(16'd10);
    repeat (2) @(negedge clk);
    check(statRdData[8] == 1'b0, "R10 length without new command ignored", int'(statRdData[8]), 0);
    runFrame(16'h0040, 400, 381, "R6 code01");
    runFrame(16'h0080, 1100, 1021, "R6 code10");
    runFrame(16'h00C0, 64, 64, "R6 code11");

    // R7 threshold beyond length
    runFrame(16'h0080, 200, 200, "R7 code10 short");
    runFrame(16'h0000, 3, 3, "R7 code00 short");
    runFrame(16'h0040, 1, 1, "R7 single byte");

    // R5 wait for space
    freeSpace = 11'd50;
    writeCmd(16'h00C0);
    expQ.push_back(100);
    writeLen(16'd100);
    repeat (4) @(negedge clk);
    check(statRdData[8] == 1'b0, "R5 ready-now held while space short", int'(statRdData[8]), 0);
    freeSpace = 11'd100;
    @(negedge clk);
    check(statRdData[8] == 1'b1, "R5 ready-now once space suffices", int'(statRdData[8]), 1);
    sendBytes(100, acc);
    check(acc == 100, "R5 bytes accepted", acc, 100);
    freeSpace = 11'd1536;

    // R3 R4 invalid lengths
    writeCmd(16'h0000);
    writeLen(16'd0);
    readStat(st);
    check(st[7] == 1'b1 && st[8] == 1'b0, "R3 zero length flags bid-error", int'(st), 16'h0080);
    readStat(st);
    check(st[7] == 1'b0, "R4 bid-error cleared by read", int'(st[7]), 0);
    writeLen(16'd60);
    repeat (2) @(negedge clk);
    check(statRdData == 16'h0, "R3 bid dropped after error", int'(statRdData), 0);
    writeCmd(16'h0000);
    writeLen(16'd1515);
    readStat(st);
    check(st[7] == 1'b1, "R3 length 1515 flags bid-error", int'(st[7]), 1);
    runFrame(16'h0000, 1514, 5, "R3 length 1514 accepted");

    // R8 options
    writeCmd(16'h3200);
    check({frameSingleAttempt, frameNoCrc, frameNoPad} == 3'b111, "R8 all options set",
          int'({frameSingleAttempt, frameNoCrc, frameNoPad}), 7);
    writeCmd(16'h1000);
    check({frameSingleAttempt, frameNoCrc, frameNoPad} == 3'b010, "R8 no-crc only",
          int'({frameSingleAttempt, frameNoCrc, frameNoPad}), 2);
    writeCmd(16'h0200);
    check({frameSingleAttempt, frameNoCrc, frameNoPad} == 3'b100, "R8 single attempt only",
          int'({frameSingleAttempt, frameNoCrc, frameNoPad}), 4);

    // R9 force discard mid-frame
    writeCmd(16'h0000);
    expQ.push_back(5);
    writeLen(16'd100);
    @(negedge clk);
    sendBytes(10, acc);
    check(flushBuf == 1'b0, "R9 no flush without force", int'(flushBuf), 0);
    writeCmd(16'h01C0);
    check(flushBuf == 1'b1, "R9 flush pulse after force", int'(flushBuf), 1);
    expQ.push_back(20);
    writeLen(16'd20);
    check(flushBuf == 1'b0, "R9 flush lasts one cycle", int'(flushBuf), 0);
    @(negedge clk);
    sendBytes(20, acc);
    check(acc == 20, "R9 new frame counted from zero", acc, 20);

    // R11 interrupt enabled / disabled
    writeCfg(16'h0100);
    writeCmd(16'h00C0);
    expQ.push_back(8);
    writeLen(16'd8);
    @(negedge clk);
    check(rdyIrq == 1'b1 && statRdData[8] == 1'b1, "R11 irq with first ready cycle", int'(rdyIrq), 1);
    @(negedge clk);
    check(rdyIrq == 1'b0, "R11 irq is one cycle", int'(rdyIrq), 0);
    sendBytes(8, acc);
    writeCfg(16'h0000);
    writeCmd(16'h00C0);
    expQ.push_back(8);
    writeLen(16'd8);
    @(negedge clk);
    check(rdyIrq == 1'b0 && statRdData[8] == 1'b1, "R11 no irq in polled mode", int'(rdyIrq), 0);
    sendBytes(8, acc);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R6 missing startTx pulses", expQ.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule